// File: doc/BRIEF.md
# Dual-Output Condensed ALU

This block is a 32-bit arithmetic and logic unit that turns one 3-bit operation code into two related result words, `ya_o` and `yb_o`, produced together. Each operation is paired so that one instruction yields two useful answers: a full-width sum next to a sum with a sign-extended 16-bit offset, a difference next to a difference with a sign-extended offset, the high and low words of an unsigned product, AND beside OR, XOR beside XNOR, or both operands with their 16-bit halves exchanged. One operation code is reserved and yields all zeros.

Each result word carries its own four-bit flag vector (zero, negative, carry, overflow). The result stage is either combinational or registered by one clock, selected by a parameter. The registered variant has a single implicit state per lane (idle after reset, then loaded every clock); its only transition is the load on each rising clock edge, and reset returns it to the cleared state.

Operation codes: 000 pass, 001 add, 010 subtract, 011 multiply, 100 AND/OR, 101 XOR/XNOR, 110 reserved, 111 half swap.

Top module: `dual_alu`

## Requirements
- R1: Op 000 sets `ya_o` = A and `yb_o` = B.
- R2: Op 001 sets `ya_o` = A + B (modulo 2^32) and `yb_o` = A + B[15:0] sign-extended from bit 15.
- R3: Op 010 sets `ya_o` = A − B and `yb_o` = A − B[15:0] sign-extended from bit 15.
- R4: Op 011 treats A and B as unsigned, putting bits 63:32 of the 64-bit product on `ya_o` and bits 31:0 on `yb_o`.
- R5: Op 100 sets `ya_o` = A & B and `yb_o` = A | B; op 101 sets `ya_o` = A ^ B and `yb_o` = ~(A ^ B).
- R6: Op 111 sets `ya_o` = {A[15:0], A[31:16]} and `yb_o` = {B[15:0], B[31:16]}.
- R7: Op 110 drives both result words and both flag vectors to zero.
- R8: Outside op 110, flag bit 3 (Z) of each vector is 1 exactly when its result word is zero, and flag bit 2 (N) equals bit 31 of that word.
- R9: For ops 001 and 010, flag bit 1 (C) is the carry out of the add, or 1 when the subtract needs no borrow (unsigned A ≥ operand); flag bit 0 (V) is 1 on signed two's-complement overflow.
- R10: For every op other than 001 and 010, flag bits 1 and 0 of both vectors are 0.
- R11: With `REG_OUT` = 1, results and flags appear one clock after the inputs are sampled, and an active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| ya_o | output | 32 | First result word |
| yb_o | output | 32 | Second result word |
| fa_o | output | 4 | Flags of `ya_o`: {Z, N, C, V} |
| fb_o | output | 4 | Flags of `yb_o`: {Z, N, C, V} |

## Verification
The bench builds two copies at the default 32-bit width with a 16-bit offset field: one with `REG_OUT` = 1 and one with `REG_OUT` = 0. Running both on the same stimulus makes the one-clock latency and reset clearing of the registered variant visible against the same-cycle answers of the combinational one. The 32-bit width reaches the carry, overflow and borrow boundaries at 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and the 16-bit offset field reaches the sign-extension boundary at bit 15.

// File: rtl/dalu_pkg.sv
package dalu_pkg;

    typedef enum logic [2:0] {
        OP_PASS  = 3'b000,
        OP_ADD   = 3'b001,
        OP_SUB   = 3'b010,
        OP_MUL   = 3'b011,
        OP_ANDOR = 3'b100,
        OP_XOR   = 3'b101,
        OP_RSVD  = 3'b110,
        OP_SWAP  = 3'b111
    } dalu_op_e;

    localparam int FLAG_W = 4;
    localparam int FLG_Z  = 3;
    localparam int FLG_N  = 2;
    localparam int FLG_C  = 1;
    localparam int FLG_V  = 0;

endpackage

// File: rtl/dalu_addsub.sv
module dalu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o,
    output logic         c_o,
    output logic         v_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   sum;

    assign b_eff = sub_i ? ~b_i : b_i;
    assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    assign y_o   = sum[W-1:0];
    // carry out doubles as "no borrow" for subtraction
    assign c_o   = sum[W];
    assign v_o   = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);
endmodule

// File: rtl/dalu_mul.sv
module dalu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int PW = 2 * W;
    logic [PW-1:0] prod;

    assign prod = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    assign hi_o = prod[PW-1:W];
    assign lo_o = prod[W-1:0];
endmodule

// File: rtl/dalu_bitwise.sv
module dalu_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] xor_o,
    output logic [W-1:0] xnor_o,
    output logic [W-1:0] swa_o,
    output logic [W-1:0] swb_o
);
    localparam int HW = W / 2;

    assign and_o  = a_i & b_i;
    assign or_o   = a_i | b_i;
    assign xor_o  = a_i ^ b_i;
    assign xnor_o = ~(a_i ^ b_i);
    assign swa_o  = {a_i[HW-1:0], a_i[W-1:HW]};
    assign swb_o  = {b_i[HW-1:0], b_i[W-1:HW]};
endmodule

// File: rtl/dalu_flags.sv
module dalu_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0]              y_i,
    input  logic                      c_i,
    input  logic                      v_i,
    input  logic                      cv_en_i,
    input  logic                      kill_i,
    output logic [dalu_pkg::FLAG_W-1:0] f_o
);
    import dalu_pkg::*;

    always_comb begin
        f_o = '0;
        if (!kill_i) begin
            f_o[FLG_Z] = (y_i == '0);
            f_o[FLG_N] = y_i[W-1];
            f_o[FLG_C] = cv_en_i & c_i;
            f_o[FLG_V] = cv_en_i & v_i;
        end
    end
endmodule

// File: rtl/dual_alu.sv
module dual_alu #(
    parameter int W       = 32,
    parameter int OFS_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] ya_o,
    output logic [W-1:0] yb_o,
    output logic [3:0]   fa_o,
    output logic [3:0]   fb_o
);
    import dalu_pkg::*;

    localparam int LANES = 2;
    localparam int SX_W  = W - OFS_W;

    dalu_op_e op_e;
    assign op_e = dalu_op_e'(op_i);

    // lane 0 uses the full operand, lane 1 the sign-extended offset field
    logic [W-1:0] lane_b  [LANES];
    logic [W-1:0] lane_y  [LANES];
    logic         lane_c  [LANES];
    logic         lane_v  [LANES];
    logic         is_sub;

    assign is_sub    = (op_e == OP_SUB);
    assign lane_b[0] = b_i;
    assign lane_b[1] = {{SX_W{b_i[OFS_W-1]}}, b_i[OFS_W-1:0]};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dalu_addsub #(.W(W)) u_as (
            .a_i  (a_i),
            .b_i  (lane_b[g]),
            .sub_i(is_sub),
            .y_o  (lane_y[g]),
            .c_o  (lane_c[g]),
            .v_o  (lane_v[g])
        );
    end

    logic [W-1:0] mul_hi, mul_lo;
    dalu_mul #(.W(W)) u_mul (
        .a_i (a_i),
        .b_i (b_i),
        .hi_o(mul_hi),
        .lo_o(mul_lo)
    );

    logic [W-1:0] bw_and, bw_or, bw_xor, bw_xnor, bw_swa, bw_swb;
    dalu_bitwise #(.W(W)) u_bw (
        .a_i   (a_i),
        .b_i   (b_i),
        .and_o (bw_and),
        .or_o  (bw_or),
        .xor_o (bw_xor),
        .xnor_o(bw_xnor),
        .swa_o (bw_swa),
        .swb_o (bw_swb)
    );

    // result selection
    logic [W-1:0] nxt_y  [LANES];
    logic         arith;
    logic         rsvd;

    always_comb begin
        nxt_y[0] = '0;
        nxt_y[1] = '0;
        arith    = 1'b0;
        rsvd     = 1'b0;
        unique case (op_e)
            OP_PASS: begin
                nxt_y[0] = a_i;
                nxt_y[1] = b_i;
            end
            OP_ADD, OP_SUB: begin
                nxt_y[0] = lane_y[0];
                nxt_y[1] = lane_y[1];
                arith    = 1'b1;
            end
            OP_MUL: begin
                nxt_y[0] = mul_hi;
                nxt_y[1] = mul_lo;
            end
            OP_ANDOR: begin
                nxt_y[0] = bw_and;
                nxt_y[1] = bw_or;
            end
            OP_XOR: begin
                nxt_y[0] = bw_xor;
                nxt_y[1] = bw_xnor;
            end
            OP_SWAP: begin
                nxt_y[0] = bw_swa;
                nxt_y[1] = bw_swb;
            end
            OP_RSVD: begin
                rsvd = 1'b1;
            end
        endcase
    end

    logic [FLAG_W-1:0] nxt_f [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_flag
        dalu_flags #(.W(W)) u_fl (
            .y_i    (nxt_y[g]),
            .c_i    (lane_c[g]),
            .v_i    (lane_v[g]),
            .cv_en_i(arith),
            .kill_i (rsvd),
            .f_o    (nxt_f[g])
        );
    end

    // output stage
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ya_o <= '0;
                yb_o <= '0;
                fa_o <= '0;
                fb_o <= '0;
            end else begin
                ya_o <= nxt_y[0];
                yb_o <= nxt_y[1];
                fa_o <= nxt_f[0];
                fb_o <= nxt_f[1];
            end
        end
    end else begin : g_comb
        assign ya_o = nxt_y[0];
        assign yb_o = nxt_y[1];
        assign fa_o = nxt_f[0];
        assign fb_o = nxt_f[1];
    end
endmodule

// File: rtl/dual_alu_chk.sv
module dual_alu_chk #(
    parameter int W       = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] ya_o,
    input logic [W-1:0] yb_o,
    input logic [3:0]   fa_o,
    input logic [3:0]   fb_o
);
    localparam int HW = W / 2;

    // operands that belong to the results currently on the outputs
    logic [2:0]   s_op;
    logic [W-1:0] s_a, s_b;
    logic         s_vld;

    if (REG_OUT) begin : g_lag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_op  <= 3'b000;
                s_a   <= '0;
                s_b   <= '0;
                s_vld <= 1'b0;
            end else begin
                s_op  <= op_i;
                s_a   <= a_i;
                s_b   <= b_i;
                s_vld <= 1'b1;
            end
        end
    end else begin : g_now
        assign s_op  = op_i;
        assign s_a   = a_i;
        assign s_b   = b_i;
        assign s_vld = 1'b1;
    end

    a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_op == 3'b000) |-> (ya_o == s_a && yb_o == s_b));

    a_r2_add_full: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_op == 3'b001) |-> (ya_o == s_a + s_b));

    a_r5_andor: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_op == 3'b100) |-> (ya_o == (s_a & s_b) && yb_o == (s_a | s_b)));

    a_r6_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_op == 3'b111) |-> (ya_o == {s_a[HW-1:0], s_a[W-1:HW]}));

    a_r7_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_op == 3'b110) |-> (ya_o == '0 && yb_o == '0 && fa_o == 4'd0 && fb_o == 4'd0));

    a_r8_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_op != 3'b110) |-> (fa_o[3] == (ya_o == '0) && fb_o[2] == yb_o[W-1]));

    a_r9_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_op == 3'b010) |-> (fa_o[1] == (s_a >= s_b)));

    a_r10_cv_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && s_op != 3'b001 && s_op != 3'b010) |-> (fa_o[1:0] == 2'b00 && fb_o[1:0] == 2'b00));
endmodule

bind dual_alu dual_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .op_i (op_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .ya_o (ya_o),
    .yb_o (yb_o),
    .fa_o (fa_o),
    .fb_o (fb_o)
);

// File: tb/sim_dual_alu.sv
`timescale 1ns/100ps
module sim_dual_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [31:0] a = 32'd0, b = 32'd0;
    logic [31:0] ya0, yb0, ya1, yb1;
    logic [3:0]  fa0, fb0, fa1, fb1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_alu #(.W(32), .OFS_W(16), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .ya_o(ya0), .yb_o(yb0), .fa_o(fa0), .fb_o(fb0));

    dual_alu #(.W(32), .OFS_W(16), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .ya_o(ya1), .yb_o(yb1), .fa_o(fa1), .fb_o(fb1));

    // {C,V} of an add or subtract, from signed and unsigned integer arithmetic
    function automatic logic [1:0] ref_cv(bit sub, logic [31:0] x, logic [31:0] y);
        longint sx, sy, sr;
        logic c, v;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        if (sub) begin
            c  = (x >= y);
            sr = sx - sy;
        end else begin
            c  = ((longint'(x) + longint'(y)) > 64'sh0FFFF_FFFF);
            sr = sx + sy;
        end
        v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        return {c, v};
    endfunction

    // returns {ya, yb, fa, fb}
    function automatic logic [71:0] ref_alu(logic [2:0] o, logic [31:0] x, logic [31:0] y);
        logic [31:0] ra, rb, ys;
        logic [3:0]  qa, qb;
        logic [63:0] p;
        ys = 32'($signed(y[15:0]));
        ra = 0; rb = 0; qa = 0; qb = 0;
        case (o)
            3'd0: begin ra = x; rb = y; end
            3'd1: begin ra = x + y; rb = x + ys;
                        qa[1:0] = ref_cv(1'b0, x, y); qb[1:0] = ref_cv(1'b0, x, ys); end
            3'd2: begin ra = x - y; rb = x - ys;
                        qa[1:0] = ref_cv(1'b1, x, y); qb[1:0] = ref_cv(1'b1, x, ys); end
            3'd3: begin p = 64'(x) * 64'(y); ra = p[63:32]; rb = p[31:0]; end
            3'd4: begin ra = x & y; rb = x | y; end
            3'd5: begin ra = x ^ y; rb = ~(x ^ y); end
            3'd7: begin ra = {x[15:0], x[31:16]}; rb = {y[15:0], y[31:16]}; end
            default: ;
        endcase
        if (o != 3'd6) begin
            qa[3] = (ra == 0); qa[2] = ra[31];
            qb[3] = (rb == 0); qb[2] = rb[31];
        end
        return {ra, rb, qa, qb};
    endfunction

    function automatic string op_tag(logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            3'd6: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic cmp(string who, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, who, act, exp);
        end
    endtask

    task automatic cmp_all(string who, logic [2:0] o, logic [71:0] e,
                           logic [31:0] ra, logic [31:0] rb, logic [3:0] qa, logic [3:0] qb);
        string t, tcv;
        t   = op_tag(o);
        tcv = (o == 3'd6) ? "R7" : ((o == 3'd1 || o == 3'd2) ? "R9" : "R10");
        cmp({who, " ya"}, t, ra, e[71:40]);
        cmp({who, " yb"}, t, rb, e[39:8]);
        cmp({who, " fa.ZN"}, (o == 3'd6) ? "R7" : "R8", 32'(qa[3:2]), 32'(e[7:6]));
        cmp({who, " fb.ZN"}, (o == 3'd6) ? "R7" : "R8", 32'(qb[3:2]), 32'(e[3:2]));
        cmp({who, " fa.CV"}, tcv, 32'(qa[1:0]), 32'(e[5:4]));
        cmp({who, " fb.CV"}, tcv, 32'(qb[1:0]), 32'(e[1:0]));
    endtask

    logic [71:0] pend[$];
    logic [2:0]  pend_op[$];

    // one vector per clock: check the registered copy for the previous vector,
    // then drive the new one and check the combinational copy
    task automatic step(logic [2:0] o, logic [31:0] x, logic [31:0] y);
        logic [71:0] e;
        @(negedge clk);
        if (pend.size() > 0) begin
            cmp_all("R11 u0", pend_op.pop_front(), pend.pop_front(), ya0, yb0, fa0, fb0);
        end
        op = o; a = x; b = y;
        e = ref_alu(o, x, y);
        pend.push_back(e);
        pend_op.push_back(o);
        #1;
        cmp_all("u1", o, e, ya1, yb1, fa1, fb1);
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        op = 3'd1; a = 32'h1234_5678; b = 32'h0F0F_0F0F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset holds the registered outputs at zero
        cmp("u0 ya in reset", "R11", ya0, 32'd0);
        cmp("u0 yb in reset", "R11", yb0, 32'd0);
        cmp("u0 flags in reset", "R11", {24'd0, fa0, fb0}, 32'd0);
        rst_n = 1'b1;

        step(3'd0, 32'hDEAD_BEEF, 32'h0000_0000);      // R1, zero on yb
        step(3'd1, 32'hFFFF_FFFF, 32'h0000_0001);      // R2 carry, zero
        step(3'd1, 32'h7FFF_FFFF, 32'h0000_0001);      // R2 overflow
        step(3'd1, 32'h0000_0100, 32'h0001_8000);      // R2 offset sign extension
        step(3'd2, 32'h0000_5555, 32'h0000_5555);      // R3 equal: Z, no borrow
        step(3'd2, 32'h0000_0000, 32'h0000_0001);      // R3 borrow
        step(3'd2, 32'h8000_0000, 32'h0000_0001);      // R3 overflow
        step(3'd2, 32'h0000_0000, 32'h0000_8000);      // R3 negative offset
        step(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);      // R4 unsigned extremes
        step(3'd3, 32'h0001_0000, 32'h0001_0000);      // R4 low word zero
        step(3'd4, 32'hF0F0_1234, 32'h0FF0_4321);      // R5
        step(3'd5, 32'hAAAA_AAAA, 32'hAAAA_AAAA);      // R5 xor zero, xnor all ones
        step(3'd7, 32'h1234_ABCD, 32'h8000_0001);      // R6
        step(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);      // R7
        step(3'd6, 32'h0000_0000, 32'h0000_0000);      // R7 with zero operands
        for (int i = 0; i < 600; i++) begin
            step(3'(i % 8), $urandom, $urandom);
        end
        step(3'd0, 32'd0, 32'd0);

        // R11: reset in mid-run clears the registered result
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        cmp("u0 ya after async reset", "R11", ya0, 32'd0);
        cmp("u0 fb after async reset", "R11", {28'd0, fb0}, 32'd0);

        done = 1'b1;
        report();
    end
endmodule